// File: doc/BRIEF.md
# Two-Bit Counter Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating state machines, one per entry. A fetch stage presents a program counter on the lookup port and gets a taken or not-taken guess back in the same cycle, with no register in the path. When the branch later resolves in execute, the resolved PC and its real outcome go in on the update port. The addressed entry then moves one step toward that outcome on the next rising clock edge.

The table index comes from one of two sources, chosen by a mode input. In per-address mode it is a slice of low PC bits just above the instruction alignment bits. In global-history mode the same slice is XORed with a shift register that records the most recent resolved outcomes. Entries carry no tags, so unrelated branches that map to the same entry share it. The history register is not speculative: it moves only on resolved updates, and there is no repair path.

Top module: `bp_dir_predictor`

## Requirements
- R1: A synchronous active-low reset puts every table entry in state 00 and clears the history register to zero. After reset, every lookup predicts not-taken.
- R2: In per-address mode (`gshare_en_i` = 0) the index is PC bits [IDX_W+1:2]. Two PCs that differ only outside those bits share one entry.
- R3: A taken update moves state 00 to 01 and state 01 to 10.
- R4: A not-taken update moves state 01 to 00.
- R5: The prediction is taken exactly when the entry's upper state bit is set (states 10 and 11). States 00 and 01 predict not-taken.
- R6: From state 11 the prediction needs two not-taken updates in a row to become not-taken: 11 goes to 10, which still predicts taken, and then 10 goes to 01.
- R7: A taken update moves 10 to 11 and leaves 11 at 11. A not-taken update leaves 00 at 00.
- R8: While `up_valid_i` is 0, neither the table nor the history register changes, whatever `up_pc_i` and `up_taken_i` carry.
- R9: In global-history mode (`gshare_en_i` = 1) the index for both lookup and update is PC bits [IDX_W+1:2] XOR the history register. An update uses the history value from before its own shift.
- R10: Each valid update shifts the history register left by one bit and loads the outcome into bit 0 (1 = taken). This happens in both modes.
- R11: `lk_taken_o` is combinational from `lk_pc_i`. When an update writes the entry being looked up in the same cycle, the lookup returns the old state, and the new state shows from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| gshare_en_i | input | 1 | 1 = index XORed with global history, 0 = per-address index |
| lk_pc_i | input | PC_W | Fetch PC to predict |
| lk_taken_o | output | 1 | Prediction for `lk_pc_i`, 1 = taken |
| up_valid_i | input | 1 | A resolved branch is presented this cycle |
| up_pc_i | input | PC_W | PC of the resolved branch |
| up_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The prediction is due in the same cycle the lookup PC is applied. An update becomes visible only after one rising edge, in both the table and the history register, so its effect on any later prediction shows one cycle after it was presented. The bench drives all inputs on the falling edge and samples `lk_taken_o` 5 ns later, before the next rising edge. Each sample therefore shows the state left by earlier cycles, not the update presented in the same cycle. This is also how the old-value rule for a lookup and update on the same entry is checked. History effects are observed only through later lookups in global-history mode, because the history register has no port of its own.

// File: rtl/bp_pkg.sv
// Package: bp_pkg
// Shared types and state-machine functions for the direction predictor.
// Assumes a 2-bit counter encoding in which bit 1 carries the prediction.
package bp_pkg;

    // Four-state hysteresis machine, encoded so that bit 1 means "predict taken".
    typedef enum logic [1:0] {
        CTR_N_STRONG = 2'b00,
        CTR_N_WEAK   = 2'b01,
        CTR_T_WEAK   = 2'b10,
        CTR_T_STRONG = 2'b11
    } ctr_t;

    // Next state of one counter for a resolved outcome.
    function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
        ctr_t nxt;
        unique case (cur)
            CTR_N_STRONG: nxt = taken ? CTR_N_WEAK   : CTR_N_STRONG;
            CTR_N_WEAK:   nxt = taken ? CTR_T_WEAK   : CTR_N_STRONG;
            CTR_T_WEAK:   nxt = taken ? CTR_T_STRONG : CTR_N_WEAK;
            CTR_T_STRONG: nxt = taken ? CTR_T_STRONG : CTR_T_WEAK;
            default:      nxt = CTR_N_STRONG;
        endcase
        return nxt;
    endfunction

    // Prediction carried by a counter state.
    function automatic logic ctr_predict(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_ghist.sv
// Module: bp_ghist
// Global outcome history shift register.
// Shifts left on every resolved branch and loads the outcome into bit 0.
// Assumes HIST_W >= 2. There is no speculative update and no repair path.
module bp_ghist #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] hist_q;

    // History register: clear on reset, shift in the outcome on each update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], bit_in};
        end
    end

    assign hist_o = hist_q;

    // R10: a valid update shifts left and loads the outcome into bit 0.
    p_shift_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(shift_en)
        |-> hist_o == {$past(hist_o[HIST_W-2:0]), $past(bit_in)});

    // R8: with no update the history does not move.
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(shift_en) |-> $stable(hist_o));

    // R1: the first cycle out of reset shows an empty history.
    p_clear_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> hist_o == '0);

endmodule

// File: rtl/bp_index_hash.sv
// Module: bp_index_hash
// Forms a table index from a PC: the PC slice above the alignment bits,
// optionally XORed with the global history.
// Assumes ALIGN_W >= 1 and ALIGN_W + IDX_W < PC_W.
module bp_index_hash #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 8,
    parameter int ALIGN_W = 2
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [IDX_W-1:0] hist_i,
    input  logic             use_hist_i,
    output logic [IDX_W-1:0] idx_o
);

    localparam int SLICE_LO = ALIGN_W;
    localparam int SLICE_HI = ALIGN_W + IDX_W - 1;

    logic [IDX_W-1:0] pc_slice;
    logic [IDX_W-1:0] hist_mask;
    logic             unused_pc_bits;

    // Address slice used by both modes.
    assign pc_slice = pc_i[SLICE_HI:SLICE_LO];

    // History is masked out in per-address mode.
    always_comb begin
        hist_mask = use_hist_i ? hist_i : '0;
        idx_o     = pc_slice ^ hist_mask;
    end

    // Bits outside the index slice have no role in the hash.
    assign unused_pc_bits = ^{pc_i[PC_W-1:SLICE_HI+1], pc_i[SLICE_LO-1:0]};

endmodule

// File: rtl/bp_ctr_table.sv
// Module: bp_ctr_table
// Untagged table of 2^IDX_W two-bit counters held in flops.
// One combinational read port and one write port that updates on the clock
// edge. A read of the entry being written returns the value before the write.
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_state_o,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0][1:0] tbl;
    ctr_t                    wr_cur;
    ctr_t                    wr_nxt;

    // Read-modify-write path for the update port.
    always_comb begin
        wr_cur = ctr_t'(tbl[wr_idx]);
        wr_nxt = ctr_next(wr_cur, wr_taken);
    end

    // Counter storage: all entries to 00 on reset, one entry written per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_nxt;
        end
    end

    // Lookup reads the stored state directly.
    assign rd_state_o = ctr_t'(tbl[rd_idx]);

    // Shadow of the last write, kept only for the checks below.
    logic             chk_vld;
    logic [IDX_W-1:0] chk_idx;
    logic [1:0]       chk_old;
    logic             chk_tkn;

    // Records which entry was written, its old value and the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_vld <= 1'b0;
        end else begin
            chk_vld <= wr_en;
        end
        chk_idx <= wr_idx;
        chk_old <= tbl[wr_idx];
        chk_tkn <= wr_taken;
    end

    // R3: taken steps the counter up by one below saturation.
    p_taken_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld && chk_tkn && chk_old != 2'b11 |-> tbl[chk_idx] == chk_old + 2'd1);

    // R7: taken holds a saturated counter.
    p_taken_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld && chk_tkn && chk_old == 2'b11 |-> tbl[chk_idx] == 2'b11);

    // R6: not-taken steps the counter down by one above the floor.
    p_nt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld && !chk_tkn && chk_old != 2'b00 |-> tbl[chk_idx] == chk_old - 2'd1);

    // R7: not-taken holds a counter at the floor.
    p_nt_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld && !chk_tkn && chk_old == 2'b00 |-> tbl[chk_idx] == 2'b00);

    // R8: no write leaves the whole table unchanged.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !chk_vld |-> $stable(tbl));

endmodule

// File: rtl/bp_dir_predictor.sv
// Module: bp_dir_predictor
// Top of the branch direction predictor. A combinational lookup port and a
// resolved-branch update port share one counter table. The index mode is
// chosen by gshare_en_i. Assumes the update for a branch arrives after its
// lookup, and accepts aliasing and a non-speculative history.
module bp_dir_predictor
    import bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 8,
    parameter int ALIGN_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gshare_en_i,
    input  logic [PC_W-1:0] lk_pc_i,
    output logic            lk_taken_o,
    input  logic            up_valid_i,
    input  logic [PC_W-1:0] up_pc_i,
    input  logic            up_taken_i
);

    localparam int HIST_W = IDX_W;
    localparam int NPORT  = 2;
    localparam int P_LK   = 0;
    localparam int P_UP   = 1;

    logic [HIST_W-1:0] ghist;
    logic [PC_W-1:0]   port_pc  [NPORT];
    logic [IDX_W-1:0]  port_idx [NPORT];
    ctr_t              lk_state;
    logic              unused_state_lsb;

    // Route both PCs into per-port index hashes.
    always_comb begin
        port_pc[P_LK] = lk_pc_i;
        port_pc[P_UP] = up_pc_i;
    end

    // One identical index hash per port.
    for (genvar p = 0; p < NPORT; p++) begin : g_hash
        bp_index_hash #(
            .PC_W    (PC_W),
            .IDX_W   (IDX_W),
            .ALIGN_W (ALIGN_W)
        ) u_hash (
            .pc_i       (port_pc[p]),
            .hist_i     (ghist),
            .use_hist_i (gshare_en_i),
            .idx_o      (port_idx[p])
        );
    end

    bp_ghist #(
        .HIST_W (HIST_W)
    ) u_ghist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid_i),
        .bit_in   (up_taken_i),
        .hist_o   (ghist)
    );

    bp_ctr_table #(
        .IDX_W (IDX_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (port_idx[P_LK]),
        .rd_state_o (lk_state),
        .wr_en      (up_valid_i),
        .wr_idx     (port_idx[P_UP]),
        .wr_taken   (up_taken_i)
    );

    // Prediction from the looked-up state.
    assign lk_taken_o       = ctr_predict(lk_state);
    assign unused_state_lsb = lk_state[0];

    // R2: per-address mode indexes by the PC slice alone.
    p_index_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !gshare_en_i |-> port_idx[P_LK] == lk_pc_i[ALIGN_W+IDX_W-1:ALIGN_W]);

    // R9: global mode index XOR history gives back the PC slice.
    p_index_hist_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gshare_en_i |-> (port_idx[P_UP] ^ ghist) == up_pc_i[ALIGN_W+IDX_W-1:ALIGN_W]);

    // R5: prediction follows the upper state bit of the looked-up entry.
    p_pred_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken_o == (lk_state == CTR_T_WEAK || lk_state == CTR_T_STRONG));

endmodule

// File: tb/tb_bp_dir_predictor.sv
module tb_bp_dir_predictor;

    localparam int PC_W = 32;
    localparam int NV   = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            gshare_en_i = 1'b0;
    logic [PC_W-1:0] lk_pc_i = '0;
    logic            lk_taken_o;
    logic            up_valid_i = 1'b0;
    logic [PC_W-1:0] up_pc_i = '0;
    logic            up_taken_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    bp_dir_predictor dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .gshare_en_i (gshare_en_i),
        .lk_pc_i     (lk_pc_i),
        .lk_taken_o  (lk_taken_o),
        .up_valid_i  (up_valid_i),
        .up_pc_i     (up_pc_i),
        .up_taken_i  (up_taken_i)
    );

    // 50 MHz
    always #10 clk = ~clk;

    // Row: {up_valid, up_taken, expected, up_pc[15:0], lk_pc[15:0], req[3:0]}
    // Per-address mode. A = 0x0100 (index 0x40), alias 0x0500, B = 0x0104.
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 16'h0100, 16'h0100, 4'd1 },  // R1 fresh entry not-taken
        {1'b1, 1'b1, 1'b0, 16'h0100, 16'h0100, 4'd11},  // R11 same-cycle write shows old 00
        {1'b1, 1'b1, 1'b0, 16'h0100, 16'h0100, 4'd3 },  // R3 at 01 still not-taken
        {1'b0, 1'b0, 1'b1, 16'h0100, 16'h0100, 4'd3 },  // R3 reached 10
        {1'b1, 1'b1, 1'b1, 16'h0100, 16'h0100, 4'd5 },  // R5 10 predicts taken
        {1'b1, 1'b1, 1'b1, 16'h0100, 16'h0100, 4'd7 },  // R7 11 taken stays 11
        {1'b1, 1'b0, 1'b1, 16'h0100, 16'h0100, 4'd5 },  // R5 11 predicts taken
        {1'b0, 1'b0, 1'b1, 16'h0100, 16'h0100, 4'd6 },  // R6 one not-taken: 10 still taken
        {1'b1, 1'b0, 1'b1, 16'h0100, 16'h0100, 4'd6 },  // R6 second not-taken presented
        {1'b0, 1'b0, 1'b0, 16'h0100, 16'h0100, 4'd6 },  // R6 now 01 not-taken
        {1'b1, 1'b0, 1'b0, 16'h0100, 16'h0100, 4'd4 },  // R4 01 not-taken goes 00
        {1'b1, 1'b0, 1'b0, 16'h0100, 16'h0100, 4'd7 },  // R7 00 not-taken stays 00
        {1'b1, 1'b1, 1'b0, 16'h0100, 16'h0100, 4'd7 },  // R7 floor held: 00 then to 01
        {1'b1, 1'b1, 1'b0, 16'h0100, 16'h0100, 4'd3 },  // R3 01 then to 10
        {1'b0, 1'b0, 1'b1, 16'h0100, 16'h0500, 4'd2 },  // R2 alias shares entry
        {1'b0, 1'b0, 1'b0, 16'h0100, 16'h0104, 4'd2 },  // R2 neighbour untouched
        {1'b0, 1'b1, 1'b0, 16'h0104, 16'h0104, 4'd8 },  // R8 invalid taken on B
        {1'b0, 1'b0, 1'b0, 16'h0104, 16'h0104, 4'd8 },  // R8 B still 00
        {1'b0, 1'b0, 1'b1, 16'h0100, 16'h0100, 4'd8 },  // R8 invalid not-taken on A
        {1'b0, 1'b0, 1'b1, 16'h0100, 16'h0100, 4'd8 }   // R8 A still 10
    };

    // Records one comparison and reports a mismatch.
    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, got, exp);
        end
    endtask

    // Drives one cycle of stimulus at the falling edge, then samples before the rise.
    task automatic step(input logic v, input logic t, input logic [PC_W-1:0] upc,
                        input logic [PC_W-1:0] lpc, input logic exp, input string tag);
        @(negedge clk);
        up_valid_i = v;
        up_taken_i = t;
        up_pc_i    = upc;
        lk_pc_i    = lpc;
        #5;
        check(lk_taken_o, exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n      = 1'b0;
        up_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();

        // Vector walk, per-address mode.
        gshare_en_i = 1'b0;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][38], VEC[i][37], {16'h0, VEC[i][35:20]}, {16'h0, VEC[i][19:4]},
                 VEC[i][36], $sformatf("R%0d row %0d", VEC[i][3:0], i));
        end

        // R1: reset clears the trained entry.
        do_reset();
        step(1'b0, 1'b0, 32'h0, 32'h0100, 1'b0, "R1 entry cleared by reset");
        step(1'b0, 1'b0, 32'h0, 32'h0500, 1'b0, "R1 alias cleared by reset");

        // R9 / R10: drive entry 0x55 through history-hashed updates.
        gshare_en_i = 1'b1;
        step(1'b1, 1'b1, 32'h0154, 32'h0154, 1'b0, "R9 hist 0 update to entry 0x55");
        step(1'b1, 1'b1, 32'h0150, 32'h0154, 1'b0, "R10 hist 1 update 0x54^1 to entry 0x55");
        step(1'b0, 1'b0, 32'h0, 32'h0158, 1'b1, "R9 hist 3 lookup 0x56^3 hits trained entry");
        step(1'b0, 1'b0, 32'h0, 32'h0154, 1'b0, "R9 hist 3 lookup 0x55^3 misses");
        gshare_en_i = 1'b0;
        step(1'b0, 1'b0, 32'h0, 32'h0154, 1'b1, "R2 per-address view of entry 0x55");
        // R10: not-taken shifts in a 0 even in per-address mode, history becomes 6.
        step(1'b1, 1'b0, 32'h03FC, 32'h03FC, 1'b0, "R7 entry 0xFF held at 00");
        gshare_en_i = 1'b1;
        step(1'b0, 1'b0, 32'h0, 32'h014C, 1'b1, "R10 hist 6 lookup 0x53^6 hits");
        step(1'b0, 1'b0, 32'h0, 32'h0158, 1'b0, "R10 old hist 3 mapping gone");
        // R8: an invalid taken must not move the history.
        step(1'b0, 1'b1, 32'h0154, 32'h014C, 1'b1, "R8 invalid update");
        step(1'b0, 1'b0, 32'h0, 32'h014C, 1'b1, "R8 history unchanged");

        // R1: reset clears the history too, so 0x154 maps to the cleared entry 0x55.
        do_reset();
        step(1'b0, 1'b0, 32'h0, 32'h0154, 1'b0, "R1 history and table cleared");
        step(1'b0, 1'b0, 32'h0, 32'h014C, 1'b0, "R1 hashed entry cleared");

        finish_run();
    end

endmodule